// File: doc/BRIEF.md
# Raster Sync Timing Generator with Frame Counter

This block produces the horizontal and vertical timing for a parallel RGB video output. From a set of programmed line and pixel counts it drives hsync, vsync, a data-enable strobe and the coordinates of the pixel being shown. It also reports which vertical phase the raster is in, keeps a running frame number, and raises a per-frame pulse at a selectable point in the frame.

Every count is programmed as the wanted length minus one. The configuration inputs are captured into working copies only when a frame starts, so changing them while a frame is being shown leaves that frame intact. In interlaced operation each field shows half the programmed height, and the field number alternates from one field to the next.

Top module: `vtg_timing_gen`

## Requirements
- R1: The horizontal raster repeats the phases active, front porch, sync and back porch in that order. Each phase lasts its field value plus one pixels. hsync is high (active-high) exactly during the horizontal sync phase.
- R2: The vertical raster repeats the same four phases in the same order. Each phase lasts its field value plus one lines. The vertical phase changes only at the first pixel of a line. vsync is high during every pixel of the vertical sync lines.
- R3: de is high only when both the horizontal and the vertical phase are active. pix_x counts 0 upward across the active pixels of a line and pix_y counts active lines from 0. Both are 0 outside the active region.
- R4: vphase reports the vertical phase with the codes 0 active, 1 front porch, 2 sync and 3 back porch.
- R5: frame_id is 0 after reset. It increases by exactly one, as a 32-bit value that wraps, in the same output cycle in which vsync rises.
- R6: frame_irq is a one-cycle pulse. With cfg_irq_at_fp low it fires on the first pixel of vertical sync. With cfg_irq_at_fp high it fires on the first pixel of the vertical front porch.
- R7: All configuration inputs, including interlace and the pulse select, are captured at reset and at the last pixel of each frame. A change made during a frame takes effect from the first pixel of the next frame.
- R8: With cfg_interlace high, each field has (cfg_v_act_m1+1)/2 active lines. The field output alternates 0,1,0,... between successive fields, starting at 0. pix_y equals twice the line within the field plus the field bit. With interlace low, field is 0.
- R9: While rst is high all outputs are 0. The first output cycle after reset shows pixel (0,0) with de high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_h_act_m1 | input | CW | Active pixels per line minus one |
| cfg_h_fp_m1 | input | CW | Horizontal front porch minus one |
| cfg_h_sw_m1 | input | CW | Horizontal sync width minus one |
| cfg_h_bp_m1 | input | CW | Horizontal back porch minus one |
| cfg_v_act_m1 | input | CW | Active lines per frame minus one |
| cfg_v_fp_m1 | input | CW | Vertical front porch minus one |
| cfg_v_sw_m1 | input | CW | Vertical sync width minus one |
| cfg_v_bp_m1 | input | CW | Vertical back porch minus one |
| cfg_interlace | input | 1 | Half-height field mode |
| cfg_irq_at_fp | input | 1 | Frame pulse at front porch start (1) or sync start (0) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | CW | Active pixel column |
| pix_y | output | CW | Active line |
| field | output | 1 | Current field in interlaced mode |
| vphase | output | 2 | Vertical phase code |
| frame_id | output | FW | Running frame number |
| frame_irq | output | 1 | Per-frame pulse |

## Verification
Every output is one register behind the raster counters. The output present after a given clock edge therefore describes the counter state held before that edge. frame_id and frame_irq are built from the same state in the same cycle, so they move together with the vsync or vphase change that causes them. A configuration applied during a frame must show up starting with the output cycle that follows the last back-porch pixel. The bench's reference model steps once per edge, pushes the expected outputs for that edge into a queue, and a monitor pops and compares them at the following falling edge. The reference also tracks whether a configuration change is still waiting to be captured, so a mismatch in that window is reported against R7.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } phase_e;
endpackage

// File: rtl/vtg_phase_ctr.sv
module vtg_phase_ctr
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [CW-1:0] act_m1,
  input  logic [CW-1:0] fp_m1,
  input  logic [CW-1:0] sw_m1,
  input  logic [CW-1:0] bp_m1,
  output phase_e        ph,
  output logic [CW-1:0] cnt,
  output logic          last
);
  logic [CW-1:0] len_m1;

  always_comb begin
    unique case (ph)
      PH_ACT:  len_m1 = act_m1;
      PH_FP:   len_m1 = fp_m1;
      PH_SYNC: len_m1 = sw_m1;
      default: len_m1 = bp_m1;
    endcase
  end

  assign last = (ph == PH_BP) && (cnt == bp_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_ACT;
      cnt <= '0;
    end else if (adv) begin
      if (cnt == len_m1) begin
        ph  <= phase_e'(2'(ph + 2'd1));
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1 / R2: phases only ever step forward by one in ring order
  p_phase_order_r1: assert property (@(posedge clk) disable iff (rst)
    (ph != $past(ph)) |-> (2'(ph - $past(ph)) == 2'd1));

  // R2: without an advance strobe the position holds
  p_hold_no_adv_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(adv) |-> ($stable(cnt) && $stable(ph)));
endmodule

// File: rtl/vtg_shadow.sv
module vtg_shadow #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] cfg_h_act_m1,
  input  logic [CW-1:0] cfg_h_fp_m1,
  input  logic [CW-1:0] cfg_h_sw_m1,
  input  logic [CW-1:0] cfg_h_bp_m1,
  input  logic [CW-1:0] cfg_v_act_m1,
  input  logic [CW-1:0] cfg_v_fp_m1,
  input  logic [CW-1:0] cfg_v_sw_m1,
  input  logic [CW-1:0] cfg_v_bp_m1,
  input  logic          cfg_interlace,
  input  logic          cfg_irq_at_fp,
  output logic [CW-1:0] w_h_act_m1,
  output logic [CW-1:0] w_h_fp_m1,
  output logic [CW-1:0] w_h_sw_m1,
  output logic [CW-1:0] w_h_bp_m1,
  output logic [CW-1:0] w_v_act_m1,
  output logic [CW-1:0] w_v_fp_m1,
  output logic [CW-1:0] w_v_sw_m1,
  output logic [CW-1:0] w_v_bp_m1,
  output logic          w_interlace,
  output logic          w_irq_at_fp,
  output logic          field
);
  logic [CW:0]   half_lines;
  logic [CW-1:0] field_act_m1;

  always_comb begin
    half_lines   = ({1'b0, cfg_v_act_m1} + 1'b1) >> 1;
    field_act_m1 = (half_lines == '0) ? '0 : CW'(half_lines - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      w_h_act_m1  <= cfg_h_act_m1;
      w_h_fp_m1   <= cfg_h_fp_m1;
      w_h_sw_m1   <= cfg_h_sw_m1;
      w_h_bp_m1   <= cfg_h_bp_m1;
      w_v_act_m1  <= cfg_interlace ? field_act_m1 : cfg_v_act_m1;
      w_v_fp_m1   <= cfg_v_fp_m1;
      w_v_sw_m1   <= cfg_v_sw_m1;
      w_v_bp_m1   <= cfg_v_bp_m1;
      w_interlace <= cfg_interlace;
      w_irq_at_fp <= cfg_irq_at_fp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       field <= 1'b0;
    else if (load) field <= cfg_interlace ? ~field : 1'b0;
  end

  // R8: the field bit moves only when a new frame's settings are captured
  p_field_at_load_r8: assert property (@(posedge clk) disable iff (rst)
    (field != $past(field)) |-> $past(load));

  // R7: working settings change only on a capture
  p_hold_between_loads_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> ($stable(w_h_act_m1) && $stable(w_v_act_m1) && $stable(w_irq_at_fp)));
endmodule

// File: rtl/vtg_frame_ctr.sv
module vtg_frame_ctr #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vs_start,
  input  logic          fp_start,
  input  logic          sel_fp,
  output logic [FW-1:0] fid,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fid <= '0;
      irq <= 1'b0;
    end else begin
      if (vs_start) fid <= fid + 1'b1;
      irq <= sel_fp ? fp_start : vs_start;
    end
  end

  // R5: the frame number only ever steps by one
  p_fid_step_r5: assert property (@(posedge clk) disable iff (rst)
    (fid != $past(fid)) |-> (fid == FW'($past(fid) + 1'b1)));

  // R6: the frame pulse lasts a single cycle
  p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
  import vtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_h_act_m1,
  input  logic [CW-1:0] cfg_h_fp_m1,
  input  logic [CW-1:0] cfg_h_sw_m1,
  input  logic [CW-1:0] cfg_h_bp_m1,
  input  logic [CW-1:0] cfg_v_act_m1,
  input  logic [CW-1:0] cfg_v_fp_m1,
  input  logic [CW-1:0] cfg_v_sw_m1,
  input  logic [CW-1:0] cfg_v_bp_m1,
  input  logic          cfg_interlace,
  input  logic          cfg_irq_at_fp,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          field,
  output logic [1:0]    vphase,
  output logic [FW-1:0] frame_id,
  output logic          frame_irq
);
  logic [CW-1:0] w_h_act_m1, w_h_fp_m1, w_h_sw_m1, w_h_bp_m1;
  logic [CW-1:0] w_v_act_m1, w_v_fp_m1, w_v_sw_m1, w_v_bp_m1;
  logic          w_interlace, w_irq_at_fp, cur_field;
  phase_e        h_ph, v_ph;
  logic [CW-1:0] h_cnt, v_cnt;
  logic          h_last, v_last, frame_load;
  logic          line_start, vs_start, fp_start;

  assign frame_load = h_last && v_last;

  vtg_shadow #(.CW(CW)) u_shadow (
    .clk(clk), .rst(rst), .load(frame_load),
    .cfg_h_act_m1(cfg_h_act_m1), .cfg_h_fp_m1(cfg_h_fp_m1),
    .cfg_h_sw_m1(cfg_h_sw_m1), .cfg_h_bp_m1(cfg_h_bp_m1),
    .cfg_v_act_m1(cfg_v_act_m1), .cfg_v_fp_m1(cfg_v_fp_m1),
    .cfg_v_sw_m1(cfg_v_sw_m1), .cfg_v_bp_m1(cfg_v_bp_m1),
    .cfg_interlace(cfg_interlace), .cfg_irq_at_fp(cfg_irq_at_fp),
    .w_h_act_m1(w_h_act_m1), .w_h_fp_m1(w_h_fp_m1),
    .w_h_sw_m1(w_h_sw_m1), .w_h_bp_m1(w_h_bp_m1),
    .w_v_act_m1(w_v_act_m1), .w_v_fp_m1(w_v_fp_m1),
    .w_v_sw_m1(w_v_sw_m1), .w_v_bp_m1(w_v_bp_m1),
    .w_interlace(w_interlace), .w_irq_at_fp(w_irq_at_fp),
    .field(cur_field)
  );

  vtg_phase_ctr #(.CW(CW)) u_hctr (
    .clk(clk), .rst(rst), .adv(1'b1),
    .act_m1(w_h_act_m1), .fp_m1(w_h_fp_m1), .sw_m1(w_h_sw_m1), .bp_m1(w_h_bp_m1),
    .ph(h_ph), .cnt(h_cnt), .last(h_last)
  );

  vtg_phase_ctr #(.CW(CW)) u_vctr (
    .clk(clk), .rst(rst), .adv(h_last),
    .act_m1(w_v_act_m1), .fp_m1(w_v_fp_m1), .sw_m1(w_v_sw_m1), .bp_m1(w_v_bp_m1),
    .ph(v_ph), .cnt(v_cnt), .last(v_last)
  );

  assign line_start = (h_ph == PH_ACT) && (h_cnt == '0);
  assign vs_start   = line_start && (v_ph == PH_SYNC) && (v_cnt == '0);
  assign fp_start   = line_start && (v_ph == PH_FP) && (v_cnt == '0);

  vtg_frame_ctr #(.FW(FW)) u_fctr (
    .clk(clk), .rst(rst), .vs_start(vs_start), .fp_start(fp_start),
    .sel_fp(w_irq_at_fp), .fid(frame_id), .irq(frame_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync  <= 1'b0;
      vsync  <= 1'b0;
      de     <= 1'b0;
      pix_x  <= '0;
      pix_y  <= '0;
      field  <= 1'b0;
      vphase <= 2'd0;
    end else begin
      hsync  <= (h_ph == PH_SYNC);
      vsync  <= (v_ph == PH_SYNC);
      de     <= (h_ph == PH_ACT) && (v_ph == PH_ACT);
      pix_x  <= (h_ph == PH_ACT) ? h_cnt : '0;
      pix_y  <= (v_ph != PH_ACT) ? '0 :
                w_interlace ? {v_cnt[CW-2:0], cur_field} : v_cnt;
      field  <= cur_field;
      vphase <= 2'(v_ph);
    end
  end

  // R3: data enable only inside the vertical active region
  p_de_in_active_r3: assert property (@(posedge clk) disable iff (rst)
    de |-> (vphase == 2'd0));

  // R4: vsync agrees with the reported sync code
  p_vsync_code_r4: assert property (@(posedge clk) disable iff (rst)
    vsync == (vphase == 2'd2));

  // R2: vertical phase moves only after the last pixel of a line
  p_vphase_at_line_r2: assert property (@(posedge clk) disable iff (rst)
    (v_ph != $past(v_ph)) |-> $past(h_last));

  // R5: frame number moves only with a rising vsync
  p_fid_with_vsync_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_id != $past(frame_id)) |-> $rose(vsync));
endmodule

// File: tb/vtg_timing_gen_tb.sv
module vtg_timing_gen_tb;
  localparam int CW = 12;
  localparam int FW = 32;

  typedef struct packed {
    logic          hs, vs, de;
    logic [CW-1:0] x, y;
    logic          fld;
    logic [1:0]    vph;
    logic [FW-1:0] fid;
    logic          irq;
    logic          pend;
    logic          first;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] h_act = 12'd7, h_fp = 12'd1, h_sw = 12'd2, h_bp = 12'd1;
  logic [CW-1:0] v_act = 12'd3, v_fp = 12'd0, v_sw = 12'd1, v_bp = 12'd0;
  logic il = 1'b0, sel = 1'b0;

  logic hsync, vsync, de, field, frame_irq;
  logic [CW-1:0] pix_x, pix_y;
  logic [1:0] vphase;
  logic [FW-1:0] frame_id;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit cfg_dirty = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  vtg_timing_gen #(.CW(CW), .FW(FW)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_h_act_m1(h_act), .cfg_h_fp_m1(h_fp), .cfg_h_sw_m1(h_sw), .cfg_h_bp_m1(h_bp),
    .cfg_v_act_m1(v_act), .cfg_v_fp_m1(v_fp), .cfg_v_sw_m1(v_sw), .cfg_v_bp_m1(v_bp),
    .cfg_interlace(il), .cfg_irq_at_fp(sel),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .field(field), .vphase(vphase), .frame_id(frame_id), .frame_irq(frame_irq)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int mh_ph, mh_c, mv_ph, mv_c, m_fld;
  int s_ha, s_hf, s_hs, s_hb, s_va, s_vf, s_vs, s_vb, s_il, s_sel;
  longint m_fid;
  bit m_first;

  function automatic int plen(input int ph, input int a, input int f, input int s, input int b);
    return (ph == 0) ? a : (ph == 1) ? f : (ph == 2) ? s : b;
  endfunction

  task automatic capture_cfg();
    s_ha = h_act; s_hf = h_fp; s_hs = h_sw; s_hb = h_bp;
    s_va = il ? ((int'(v_act) + 1) / 2 - 1) : int'(v_act);
    s_vf = v_fp; s_vs = v_sw; s_vb = v_bp;
    s_il = il; s_sel = sel;
  endtask

  // driver side of the scoreboard: predict and push one item per edge
  always @(posedge clk) begin
    if (rst) begin
      mh_ph = 0; mh_c = 0; mv_ph = 0; mv_c = 0; m_fld = 0; m_fid = 0;
      m_first = 1'b1;
      capture_cfg();
    end else begin
      exp_t e;
      bit line0, hl, vl;
      line0 = (mh_ph == 0) && (mh_c == 0);
      if (line0 && mv_ph == 2 && mv_c == 0) m_fid++;
      e.hs    = (mh_ph == 2);
      e.vs    = (mv_ph == 2);
      e.de    = (mh_ph == 0) && (mv_ph == 0);
      e.x     = (mh_ph == 0) ? CW'(mh_c) : '0;
      e.y     = (mv_ph != 0) ? '0 : (s_il != 0) ? CW'(mv_c * 2 + m_fld) : CW'(mv_c);
      e.fld   = m_fld[0];
      e.vph   = 2'(mv_ph);
      e.fid   = FW'(m_fid);
      e.irq   = line0 && mv_c == 0 && ((s_sel != 0) ? (mv_ph == 1) : (mv_ph == 2));
      e.pend  = cfg_dirty;
      e.first = m_first;
      m_first = 1'b0;
      q.push_back(e);
      hl = (mh_ph == 3) && (mh_c == s_hb);
      vl = (mv_ph == 3) && (mv_c == s_vb);
      if (mh_c == plen(mh_ph, s_ha, s_hf, s_hs, s_hb)) begin
        mh_ph = (mh_ph + 1) % 4; mh_c = 0;
      end else mh_c++;
      if (hl) begin
        if (mv_c == plen(mv_ph, s_va, s_vf, s_vs, s_vb)) begin
          mv_ph = (mv_ph + 1) % 4; mv_c = 0;
        end else mv_c++;
      end
      if (hl && vl) begin
        m_fld = il ? 1 - m_fld : 0;
        capture_cfg();
        cfg_dirty = 1'b0;
      end
    end
  end

  // monitor side: pop and compare away from the active edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      string t7;
      e = q.pop_front();
      t7 = e.pend ? "/R7" : "";
      check(hsync == e.hs, {"R1 hsync", t7}, hsync, e.hs);
      check(vsync == e.vs, {"R2 vsync", t7}, vsync, e.vs);
      check(de == e.de, {"R3 de", t7}, de, e.de);
      check(pix_x == e.x, {"R3 pix_x", t7}, pix_x, e.x);
      check(pix_y == e.y, {"R3/R8 pix_y", t7}, pix_y, e.y);
      check(vphase == e.vph, {"R4 vphase", t7}, vphase, e.vph);
      check(frame_id == e.fid, "R5 frame_id", frame_id, e.fid);
      check(frame_irq == e.irq, {"R6 frame_irq", t7}, frame_irq, e.irq);
      check(field == e.fld, {"R8 field", t7}, field, e.fld);
      if (e.first)
        check(de && pix_x == 0 && pix_y == 0, "R9 first pixel", {de, pix_x, pix_y}, {1'b1, 24'd0});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9: everything zero while held in reset
    check({hsync, vsync, de, pix_x, pix_y, field, vphase, frame_irq} == '0,
          "R9 reset outputs", {hsync, vsync, de, pix_x, pix_y, field, vphase, frame_irq}, 0);
    check(frame_id == '0, "R9/R5 reset frame_id", frame_id, 0);
    rst = 1'b0;
    // progressive, pulse at sync start: two frames of 15x8
    repeat (260) @(negedge clk);
    // R7: reprogram mid-frame, pulse moves to front porch
    h_act = 12'd5; v_fp = 12'd1; sel = 1'b1; cfg_dirty = 1'b1;
    repeat (330) @(negedge clk);
    // R8: interlaced fields of half height
    v_act = 12'd5; il = 1'b1; cfg_dirty = 1'b1;
    repeat (500) @(negedge clk);
    // back to progressive mid-field, pulse at sync again
    il = 1'b0; sel = 1'b0; h_bp = 12'd0; cfg_dirty = 1'b1;
    repeat (300) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule